// File: doc/BRIEF.md
# Circular Command Ring Writer

This block takes command words from a staging stream and stores them into a circular ring held in an internal dual-port RAM. It keeps its own write index, which wraps to zero after the last ring slot. After it stores a word it compares the advanced index with the consumer's read pointer. If the two are equal, the ring is full. The writer then stops taking words and polls the read pointer once per cycle until the value changes. If that wait lasts a set number of polls, the block sends an engine-reset request.

A batch ends with the word flagged as last. At that point, if the write index is below the mirror size, the writer copies the first mirror-size ring words into an equal number of extra slots placed just past the ring end. A consumer that fetches a short wrapping packet beyond the ring end then still reads valid data. Only after all stores and any copy are complete does the writer publish the new write index to the consumer's write-pointer register. Each memory write also appears on a registered write port, so neighbouring logic or a bench can follow the ring contents.

Top module: `cmd_ring_writer`

## Requirements
- R1: After synchronous reset the write index and the published pointer are 0, `in_ready` is 1, and `mem_we`, `wptr_pub_stb` and `reset_req` are 0.
- R2: A word accepted while `in_valid` and `in_ready` are both high is written to ring slot equal to the current write index. That write appears on `mem_we`/`mem_idx`/`mem_wdata` one cycle later. The index then advances by one, and from RING_WORDS-1 it goes to 0.
- R3: If the advanced index equals `rd_ptr`, `in_ready` is 0 from the next cycle on. The writer compares `rd_ptr` each cycle and raises `in_ready` again in the cycle after the first compare in which they differ (unless the stalled word ended a batch).
- R4: During a stall, `reset_req` pulses for exactly one cycle after TIMEOUT_POLLS consecutive failed polls. Counting then restarts, and leaving the stall clears the count.
- R5: After the last word of a batch (and any stall on it), if the write index is below MIRROR_WORDS, ring words 0 to MIRROR_WORDS-1 are copied in ascending order to memory slots RING_WORDS+0 onward, one per cycle, each copy carrying the value currently stored in its source slot.
- R6: If the write index at the end of a batch is MIRROR_WORDS or more, no write to a slot at or above RING_WORDS occurs.
- R7: `wptr_pub` takes the new write index, with a one-cycle `wptr_pub_stb`, only after every store and mirror copy of the batch is done. Otherwise it holds its value.
- R8: No word is accepted while the writer is stalled, copying the mirror or publishing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Staging word present |
| in_data | input | DATA_W | Command word |
| in_last | input | 1 | Word closes the batch |
| in_ready | output | 1 | Writer will take a word this cycle |
| rd_ptr | input | IDX_W | Consumer read index |
| mem_we | output | 1 | A RAM write happened in the previous cycle |
| mem_idx | output | MEM_AW | Slot of that write |
| mem_wdata | output | DATA_W | Data of that write |
| wptr_pub | output | IDX_W | Write index as published to the consumer |
| wptr_pub_stb | output | 1 | One-cycle pulse when `wptr_pub` updates |
| reset_req | output | 1 | One-cycle engine-reset request on stall timeout |

## Verification
Random batches of 1 to 20 words, with random gaps and a read pointer kept clear of the writer, test storage order and wrap against a scoreboard of expected writes. That scoreboard also holds the expected mirror images built from a model of the RAM. A batch that ends at index 31 and one that ends at 32 show where the mirror copy switches off, and a batch that ends exactly on index 0 tests wrap together with mirroring. Directed collisions, one in mid-batch and one on the closing word, show the difference between a plain stall, the timeout pulse and its exact cycle, and publication that is delayed by a stall.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [1:0] {
    ST_TAKE = 2'd0,
    ST_HOLD = 2'd1,
    ST_COPY = 2'd2,
    ST_POST = 2'd3
  } wr_state_e;
endpackage

// File: rtl/cmd_ring_ram.sv
module cmd_ring_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 96,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/cmd_ring_poll_timer.sv
module cmd_ring_poll_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !poll) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == CW'(LIMIT - 1)) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end

  // R4: the request is a single-cycle pulse
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    expire && (LIMIT > 1) |=> !expire);
endmodule

// File: rtl/cmd_ring_mirror.sv
module cmd_ring_mirror #(
  parameter int COPY_WORDS = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  output logic [$clog2(COPY_WORDS)-1:0] rd_addr,
  output logic                          wr_en,
  output logic [$clog2(COPY_WORDS)-1:0] wr_off,
  output logic                          done
);
  localparam int OW = $clog2(COPY_WORDS);
  localparam int RW = $clog2(COPY_WORDS + 1);

  logic [RW-1:0] rcnt;
  logic          issue;
  logic          wv;
  logic [OW-1:0] woff;

  assign issue   = run && (rcnt < RW'(COPY_WORDS));
  assign rd_addr = rcnt[OW-1:0];
  assign wr_en   = wv;
  assign wr_off  = woff;
  assign done    = wv && (woff == OW'(COPY_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      rcnt <= '0;
      wv   <= 1'b0;
      woff <= '0;
    end else begin
      if (issue) rcnt <= rcnt + 1'b1;
      wv   <= issue;
      woff <= rcnt[OW-1:0];
    end
  end

  // R5: completion only after every source word was read
  p_done_full_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> rcnt == RW'(COPY_WORDS));
  // R5: copies walk upward one slot per cycle
  p_copy_step_r5: assert property (@(posedge clk) disable iff (rst)
    wv && !done |=> wv && woff == $past(woff) + 1'b1);
endmodule

// File: rtl/cmd_ring_writer.sv
module cmd_ring_writer
  import cmd_ring_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int RING_WORDS    = 512,
  parameter int MIRROR_WORDS  = 32,
  parameter int TIMEOUT_POLLS = 1000000,
  parameter int IDX_W         = $clog2(RING_WORDS),
  parameter int MEM_AW        = $clog2(RING_WORDS + MIRROR_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  rd_ptr,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]  wptr_pub,
  output logic              wptr_pub_stb,
  output logic              reset_req
);
  localparam int MEM_WORDS = RING_WORDS + MIRROR_WORDS;
  localparam int OW        = $clog2(MIRROR_WORDS);
  localparam logic [IDX_W:0]  MIR_LIM  = (IDX_W + 1)'(MIRROR_WORDS);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RING_WORDS - 1);

  wr_state_e         state;
  logic [IDX_W-1:0]  wr_idx;
  logic              batch_end;
  logic [IDX_W-1:0]  idx_adv;
  logic              take;
  logic              collide_now;
  logic              poll;

  logic              ram_we;
  logic [MEM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [MEM_AW-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_rdata;

  logic [OW-1:0]     mir_rd;
  logic              mir_we;
  logic [OW-1:0]     mir_off;
  logic              mir_done;

  function automatic wr_state_e settle(input logic [IDX_W-1:0] idx);
    return ({1'b0, idx} < MIR_LIM) ? ST_COPY : ST_POST;
  endfunction

  assign in_ready    = (state == ST_TAKE);
  assign take        = in_ready && in_valid;
  assign idx_adv     = (wr_idx == IDX_TOP) ? '0 : wr_idx + 1'b1;
  assign collide_now = (idx_adv == rd_ptr);
  assign poll        = (state == ST_HOLD) && (rd_ptr == wr_idx);

  always_comb begin
    ram_we    = take || mir_we;
    ram_waddr = take ? MEM_AW'(wr_idx)
                     : MEM_AW'(RING_WORDS) + MEM_AW'(mir_off);
    ram_wdata = take ? in_data : ram_rdata;
    ram_raddr = MEM_AW'(mir_rd);
  end

  cmd_ring_ram #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS), .AW(MEM_AW)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr (ram_raddr),
    .rd_data (ram_rdata)
  );

  cmd_ring_mirror #(.COPY_WORDS(MIRROR_WORDS)) u_mirror (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_COPY),
    .rd_addr (mir_rd),
    .wr_en   (mir_we),
    .wr_off  (mir_off),
    .done    (mir_done)
  );

  cmd_ring_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .poll   (poll),
    .expire (reset_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_TAKE;
      wr_idx       <= '0;
      batch_end    <= 1'b0;
      wptr_pub     <= '0;
      wptr_pub_stb <= 1'b0;
      mem_we       <= 1'b0;
      mem_idx      <= '0;
      mem_wdata    <= '0;
    end else begin
      wptr_pub_stb <= 1'b0;
      mem_we       <= ram_we;
      mem_idx      <= ram_waddr;
      mem_wdata    <= ram_wdata;
      unique case (state)
        ST_TAKE: if (in_valid) begin
          wr_idx    <= idx_adv;
          batch_end <= in_last;
          if (collide_now)  state <= ST_HOLD;
          else if (in_last) state <= settle(idx_adv);
        end
        ST_HOLD: if (rd_ptr != wr_idx) begin
          state <= batch_end ? settle(wr_idx) : ST_TAKE;
        end
        ST_COPY: if (mir_done) state <= ST_POST;
        ST_POST: begin
          wptr_pub     <= wr_idx;
          wptr_pub_stb <= 1'b1;
          batch_end    <= 1'b0;
          state        <= ST_TAKE;
        end
        default: state <= ST_TAKE;
      endcase
    end
  end

  // R2: index advance and wrap
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    take && wr_idx == IDX_TOP |=> wr_idx == '0);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    take && wr_idx != IDX_TOP |=> wr_idx == $past(wr_idx) + 1'b1);
  // R3: collision stops intake next cycle
  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    take && collide_now |=> !in_ready);
  p_resume_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLD && rd_ptr != wr_idx && !batch_end |=> in_ready);
  // R6: mirror only for a low closing index
  p_copy_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_COPY) |-> {1'b0, wr_idx} < MIR_LIM);
  // R7: published pointer moves only on its strobe
  p_pub_hold_r7: assert property (@(posedge clk) disable iff (rst)
    state != ST_POST |=> $stable(wptr_pub));
  // R8: no intake while copying
  p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    mir_we |-> !in_ready);
endmodule

// File: tb/cmd_ring_writer_test.sv
module cmd_ring_writer_test;
  localparam int DW   = 32;
  localparam int RING = 64;
  localparam int MIR  = 32;
  localparam int TMO  = 40;
  localparam int IW   = $clog2(RING);
  localparam int AW   = $clog2(RING + MIR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          in_ready;
  logic [IW-1:0] rd_ptr = '0;
  logic          mem_we;
  logic [AW-1:0] mem_idx;
  logic [DW-1:0] mem_wdata;
  logic [IW-1:0] wptr_pub;
  logic          wptr_pub_stb;
  logic          reset_req;

  always #5 clk = ~clk;

  cmd_ring_writer #(.DATA_W(DW), .RING_WORDS(RING), .MIRROR_WORDS(MIR),
                    .TIMEOUT_POLLS(TMO)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .rd_ptr(rd_ptr),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
    .wptr_pub(wptr_pub), .wptr_pub_stb(wptr_pub_stb), .reset_req(reset_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_idx[$];
  logic [DW-1:0] exp_dat[$];
  int exp_pub[$];
  logic [DW-1:0] model_mem [RING + MIR];
  int model_w = 0;
  int mir_seen = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrap_add(input int a, input int b);
    return (a + b) % RING;
  endfunction

  // scoreboard of RAM writes and publications
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (mem_we) begin
        if (int'(mem_idx) >= RING) mir_seen++;
        if (exp_idx.size() == 0) begin
          chk(1'b0, int'(mem_idx) >= RING ? "R6" : "R2", DW'(mem_idx), '1);
        end else begin
          int ei;
          logic [DW-1:0] ed;
          ei = exp_idx.pop_front();
          ed = exp_dat.pop_front();
          chk(int'(mem_idx) == ei, ei >= RING ? "R5" : "R2", DW'(mem_idx), DW'(ei));
          chk(mem_wdata == ed, ei >= RING ? "R5" : "R2", mem_wdata, ed);
        end
      end
      if (wptr_pub_stb) begin
        chk(exp_idx.size() == 0, "R7", DW'(exp_idx.size()), 0);
        if (exp_pub.size() == 0) chk(1'b0, "R7", DW'(wptr_pub), '1);
        else begin
          int ep;
          ep = exp_pub.pop_front();
          chk(int'(wptr_pub) == ep, "R7", DW'(wptr_pub), DW'(ep));
        end
      end
    end
  end

  task automatic push(input logic [DW-1:0] d, input bit last);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    while (!in_ready) @(negedge clk);
    exp_idx.push_back(model_w);
    exp_dat.push_back(d);
    model_mem[model_w] = d;
    model_w = wrap_add(model_w, 1);
    if (last) begin
      if (model_w < MIR) begin
        for (int k = 0; k < MIR; k++) begin
          exp_idx.push_back(RING + k);
          exp_dat.push_back(model_mem[k]);
          model_mem[RING + k] = model_mem[k];
        end
      end
      exp_pub.push_back(model_w);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic send_batch(input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      push($urandom, i == len - 1);
      if (gaps) repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (exp_idx.size() != 0 || exp_pub.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", DW'(in_ready), 1);
    chk(wptr_pub == '0, "R1", DW'(wptr_pub), 0);
    chk(!mem_we && !wptr_pub_stb && !reset_req, "R1",
        DW'({mem_we, wptr_pub_stb, reset_req}), 0);
    mon_on = 1'b1;

    // fill most of the ring, no mirror (end 60)
    rd_ptr = IW'(63);
    send_batch(60, 1'b0);
    wait_idle();
    chk(int'(wptr_pub) == 60, "R7", DW'(wptr_pub), 60);

    // wrap with mirror (end 6) - R2 and R5
    rd_ptr = IW'(40);
    send_batch(10, 1'b1);
    wait_idle();
    chk(int'(wptr_pub) == 6, "R5", DW'(wptr_pub), 6);

    // boundary: end at 31 mirrors (R5), end at 32 does not (R6)
    rd_ptr = IW'(50);
    mir_seen = 0;
    send_batch(25, 1'b0);
    wait_idle();
    chk(mir_seen == MIR, "R5", DW'(mir_seen), MIR);
    mir_seen = 0;
    send_batch(1, 1'b0);
    wait_idle();
    chk(mir_seen == 0, "R6", DW'(mir_seen), 0);
    chk(int'(wptr_pub) == 32, "R6", DW'(wptr_pub), 32);

    // random batches, read pointer kept clear
    for (int b = 0; b < 30; b++) begin
      int len;
      len = 1 + ($urandom % 20);
      rd_ptr = IW'(wrap_add(model_w, len + 1 + ($urandom % (RING - len - 1))));
      send_batch(len, 1'b1);
      wait_idle();
    end

    // mid-batch stall with timeout - R3 R4 R8
    begin
      int stop;
      stop = wrap_add(model_w, 5);
      rd_ptr = IW'(stop);
      for (int i = 0; i < 5; i++) push($urandom, 1'b0);
      in_valid = 1'b1;
      in_data  = 32'hDEAD_BEEF;
      chk(in_ready == 1'b0, "R3", DW'(in_ready), 0);
      for (int n = 1; n <= TMO + 1; n++) begin
        @(negedge clk);
        chk(reset_req == (n == TMO), "R4", DW'(reset_req), DW'(n == TMO));
        chk(in_ready == 1'b0, "R8", DW'(in_ready), 0);
        chk(!mem_we, "R8", DW'(mem_we), 0);
      end
      in_valid = 1'b0;
      rd_ptr = IW'(wrap_add(stop, 10));
      @(negedge clk);
      chk(in_ready == 1'b1, "R3", DW'(in_ready), 1);
      chk(reset_req == 1'b0, "R4", DW'(reset_req), 0);
      push($urandom, 1'b1);
      wait_idle();
    end

    // stall on closing word delays publication - R3 R7
    begin
      logic [IW-1:0] pub_before;
      rd_ptr = IW'(wrap_add(model_w, 3));
      push($urandom, 1'b0);
      push($urandom, 1'b0);
      pub_before = wptr_pub;
      push($urandom, 1'b1);
      chk(in_ready == 1'b0, "R3", DW'(in_ready), 0);
      repeat (6) @(negedge clk);
      chk(wptr_pub == pub_before && !wptr_pub_stb, "R7", DW'(wptr_pub), DW'(pub_before));
      rd_ptr = IW'(wrap_add(model_w, 20));
      wait_idle();
      chk(int'(wptr_pub) == model_w, "R7", DW'(wptr_pub), DW'(model_w));
    end

    // batch ending exactly on index 0: wrap plus mirror - R2 R5
    begin
      int len;
      if (model_w == 0) begin
        rd_ptr = IW'(RING / 2);
        send_batch(1, 1'b0);
        wait_idle();
      end
      len = RING - model_w;
      rd_ptr = IW'(model_w - 1);
      mir_seen = 0;
      send_batch(len, 1'b0);
      wait_idle();
      chk(wptr_pub == '0, "R2", DW'(wptr_pub), 0);
      chk(mir_seen == MIR, "R5", DW'(mir_seen), MIR);
    end

    chk(exp_idx.size() == 0 && exp_pub.size() == 0, "R7",
        DW'(exp_idx.size() + exp_pub.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule